// File: doc/BRIEF.md
# Fault-Tolerant Programmable LFSR Generator

This block produces pseudo-random test patterns from a linear feedback shift register whose length (2 to 32 bits) and feedback taps are set at run time. The generator uses the Fibonacci form. On each step the parity of the tapped state bits becomes the new bit 0, and the rest of the register moves one place toward the most significant bit.

The state is kept in three identical copies. The output and the next state are both taken from a bitwise two-out-of-three vote. Every enabled update writes the voted value back into all three copies, so an upset in one copy is repaired within one step. The register only updates when a load, a run step or a deliberate upset injection occurs, which models a gated clock. An injection port can flip any bits of one chosen copy, so the voting can be tested on the chip.

Top module: `ftlfsr_gen`

## Requirements
- R1: After reset `rnd_out` is 0, `rnd_valid` is 0, `upset_flag` is 0, and the internal state is 1, so the first run step from reset produces the step of value 1.
- R2: The effective degree is `cfg_deg` clamped to the range 2..32 (values 0 and 1 act as 2, values above 32 act as 32). Bits of `rnd_out` at or above the effective degree are always 0 after a load or step.
- R3: A run step produces `((S << 1) | p) & M`, where S is the voted state, M is the degree mask, and p is the parity of `S & cfg_taps & M`.
- R4: Tap mask bits at or above the effective degree have no effect on the sequence.
- R5: When `load` is high, the state and `rnd_out` take `cfg_seed & M`, or 1 if that masked value is zero. Load takes priority over `run` in the same cycle.
- R6: When `run` and `load` are both low, the state and `rnd_out` hold their values.
- R7: `rnd_valid` equals the value of `run` one cycle earlier.
- R8: XOR-ing any mask into a single copy (`inj_copy` 0, 1 or 2) never changes `rnd_out` or the sequence that follows.
- R9: A copy disagreement present after a clock edge raises `upset_flag` at the next edge. Any load or run step without a new injection clears the disagreement, so the flag is a one-cycle pulse while running and stays high while idle.
- R10: An `inj_copy` value of 3 injects nothing, even when `inj_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_deg | input | 6 | Polynomial degree |
| cfg_taps | input | 32 | Feedback tap mask, bit i taps state bit i |
| cfg_seed | input | 32 | Seed value for load |
| load | input | 1 | Load seed into all copies |
| run | input | 1 | Advance the register one step |
| inj_en | input | 1 | Apply an upset this cycle |
| inj_copy | input | 2 | Copy to upset (0..2; 3 means none) |
| inj_mask | input | 32 | Bits to flip in the chosen copy |
| rnd_out | output | 32 | Registered voted state |
| rnd_valid | output | 1 | Run delayed by one cycle |
| upset_flag | output | 1 | Copies disagreed in the previous cycle |

## Verification
Two pairs of events can fall in the same cycle. A load can coincide with a run step, and an upset injection can coincide with a load or a run step. The bench drives `load` and `run` high together and expects the masked seed, not a step. It also injects into one copy while the register is stepping and while it is idle. A behavioural model runs alongside the design and is compared on every clock. The model expects an unchanged output in every case, a one-cycle flag pulse while running, and a flag that stays high while idle.

// File: rtl/ftlfsr_pkg.sv
package ftlfsr_pkg;
  localparam int unsigned NCOPY = 3;
  localparam logic [1:0] COPY_NONE = 2'd3;

  function automatic logic odd_parity32(input logic [31:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/ftlfsr_step.sv
module ftlfsr_step #(
  parameter int unsigned W  = 32,
  parameter int unsigned DW = $clog2(W + 1)
) (
  input  logic [W-1:0]  state,
  input  logic [W-1:0]  taps,
  input  logic [DW-1:0] deg,
  output logic [W-1:0]  mask,
  output logic [W-1:0]  nxt
);
  localparam logic [DW-1:0] MIN_DEG = DW'(2);
  localparam logic [DW-1:0] MAX_DEG = DW'(W);

  logic [DW-1:0] eff;
  logic          fb;

  always_comb begin
    if (deg < MIN_DEG)      eff = MIN_DEG;
    else if (deg > MAX_DEG) eff = MAX_DEG;
    else                    eff = deg;
  end

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (DW'(i) < eff);
  end

  assign fb  = ^(state & taps & mask);
  assign nxt = {state[W-2:0], fb} & mask;
endmodule

// File: rtl/ftlfsr_vote.sv
module ftlfsr_vote #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y,
  output logic         disagree
);
  logic [W-1:0] diff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i]    = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    assign diff[i] = (a[i] ^ b[i]) | (a[i] ^ c[i]);
  end

  assign disagree = |diff;

  // R8: any two agreeing copies decide the vote
  always_comb begin
    if (a == b) p_vote_ab_r8: assert (y == a);
    if (a == c) p_vote_ac_r8: assert (y == a);
    if (b == c) p_vote_bc_r8: assert (y == b);
  end
endmodule

// File: rtl/ftlfsr_gen.sv
module ftlfsr_gen #(
  parameter int unsigned W  = 32,
  parameter int unsigned DW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cfg_deg,
  input  logic [W-1:0]  cfg_taps,
  input  logic [W-1:0]  cfg_seed,
  input  logic          load,
  input  logic          run,
  input  logic          inj_en,
  input  logic [1:0]    inj_copy,
  input  logic [W-1:0]  inj_mask,
  output logic [W-1:0]  rnd_out,
  output logic          rnd_valid,
  output logic          upset_flag
);
  import ftlfsr_pkg::*;

  logic [W-1:0] cp [NCOPY];
  logic [W-1:0] voted, mask, step_val, seed_m, wr_val;
  logic         disagree, inj_hit, wr, en;

  ftlfsr_vote #(.W(W)) i_vote (
    .a(cp[0]), .b(cp[1]), .c(cp[2]), .y(voted), .disagree(disagree)
  );

  ftlfsr_step #(.W(W), .DW(DW)) i_step (
    .state(voted), .taps(cfg_taps), .deg(cfg_deg), .mask(mask), .nxt(step_val)
  );

  assign seed_m  = cfg_seed & mask;
  assign inj_hit = inj_en && (inj_copy != COPY_NONE);
  assign wr      = load | run;
  assign en      = wr | inj_hit;

  always_comb begin
    if (load)
      wr_val = (seed_m == '0) ? W'(1) : seed_m;
    else
      wr_val = step_val;
  end

  // clock-gated state: only updates when en is asserted
  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst)
        cp[k] <= W'(1);
      else if (en)
        cp[k] <= (wr ? wr_val : cp[k]) ^
                 ((inj_hit && (inj_copy == 2'(k))) ? inj_mask : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_out    <= '0;
      rnd_valid  <= 1'b0;
      upset_flag <= 1'b0;
    end else begin
      if (wr) rnd_out <= wr_val;
      rnd_valid  <= run;
      upset_flag <= disagree;
    end
  end

  p_valid_r7: assert property (@(posedge clk) disable iff (rst)
    run |=> rnd_valid);
  p_novalid_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> !rnd_valid);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(rnd_out));
  p_seed_nz_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (rnd_out != '0));
  p_mask_r2: assert property (@(posedge clk) disable iff (rst)
    wr |=> ((rnd_out & ~$past(mask)) == '0));
  p_scrub_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && !inj_hit) |=> (cp[0] == cp[1] && cp[1] == cp[2]));
  p_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (inj_hit && inj_mask != '0) |=> ##1 upset_flag);
  p_none_r10: assert property (@(posedge clk) disable iff (rst)
    (inj_en && inj_copy == COPY_NONE && !wr && !disagree) |=> !disagree);
endmodule

// File: tb/test_ftlfsr_gen.sv
module test_ftlfsr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cfg_deg = 6'd4;
  logic [31:0] cfg_taps = 32'hC;
  logic [31:0] cfg_seed = 32'h0;
  logic        load = 1'b0, run = 1'b0, inj_en = 1'b0;
  logic [1:0]  inj_copy = 2'd3;
  logic [31:0] inj_mask = 32'h0;
  logic [31:0] rnd_out;
  logic        rnd_valid, upset_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ftlfsr_gen i_ftlfsr_gen (
    .clk(clk), .rst(rst), .cfg_deg(cfg_deg), .cfg_taps(cfg_taps),
    .cfg_seed(cfg_seed), .load(load), .run(run), .inj_en(inj_en),
    .inj_copy(inj_copy), .inj_mask(inj_mask), .rnd_out(rnd_out),
    .rnd_valid(rnd_valid), .upset_flag(upset_flag)
  );

  // behavioural reference model
  logic [31:0] m_st, m_out;
  logic        m_val, m_flag, m_dis;

  function automatic logic [31:0] mask_of(input int d);
    int e;
    e = (d < 2) ? 2 : ((d > 32) ? 32 : d);
    return (e == 32) ? 32'hFFFF_FFFF : ((32'h1 << e) - 32'h1);
  endfunction

  function automatic logic [31:0] step_of(input logic [31:0] s, input logic [31:0] t, input int d);
    logic [31:0] mk;
    logic fb;
    mk = mask_of(d);
    fb = ^(s & t & mk);
    return ((s << 1) | {31'h0, fb}) & mk;
  endfunction

  always @(posedge clk) begin
    logic [31:0] mk, sd;
    logic hit;
    if (rst) begin
      m_st = 32'h1; m_out = 0; m_val = 0; m_flag = 0; m_dis = 0;
    end else begin
      mk  = mask_of(int'(cfg_deg));
      hit = inj_en && inj_copy != 2'd3;
      m_flag = m_dis;
      if (hit && inj_mask != 0) m_dis = 1'b1;
      else if (load || run)     m_dis = 1'b0;
      if (load) begin
        sd = cfg_seed & mk;
        m_st = (sd == 0) ? 32'h1 : sd;
        m_out = m_st;
      end else if (run) begin
        m_st = step_of(m_st, cfg_taps, int'(cfg_deg));
        m_out = m_st;
      end
      m_val = run;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(rnd_out == m_out, "R3/R5/R8 rnd_out", rnd_out, m_out);
      chk(rnd_valid == m_val, "R7 rnd_valid", {31'h0, rnd_valid}, {31'h0, m_val});
      chk(upset_flag == m_flag, "R9 upset_flag", {31'h0, upset_flag}, {31'h0, m_flag});
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_load(input logic [31:0] s);
    cfg_seed = s; load = 1; tick(1); load = 0;
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    chk(rnd_out == 0 && !rnd_valid && !upset_flag, "R1 reset state", rnd_out, 0);
    // R1: first step from reset state 1
    run = 1; tick(1); run = 0;
    chk(rnd_out == 32'h2, "R1 first step", rnd_out, 32'h2);

    // R3: degree 4, x^4+x^3+1, period 15
    cfg_deg = 4; cfg_taps = 32'hC;
    do_load(32'h9);
    run = 1; tick(15); run = 0;
    chk(rnd_out == 32'h9, "R3 period 15", rnd_out, 32'h9);

    // R5: zero masked seed replaced by 1, high bits masked
    do_load(32'hFFFF_FFF0);
    chk(rnd_out == 32'h1, "R5 zero seed", rnd_out, 32'h1);
    do_load(32'hABCD_EF5A);
    chk(rnd_out == 32'hA, "R5 seed masked R2", rnd_out, 32'hA);

    // R6: idle hold
    tick(5);
    chk(rnd_out == 32'hA, "R6 hold", rnd_out, 32'hA);

    // R5: load wins over run
    cfg_seed = 32'h3; load = 1; run = 1; tick(1); load = 0;
    chk(rnd_out == 32'h3, "R5 load priority", rnd_out, 32'h3);
    chk(rnd_valid == 1'b1, "R7 valid with load", {31'h0, rnd_valid}, 1);
    tick(4); run = 0;

    // R4: taps above degree ignored
    cfg_taps = 32'hFFFF_FFFC;
    run = 1; tick(20); run = 0;

    // R8/R9: injection while running
    cfg_taps = 32'hC;
    run = 1; inj_en = 1; inj_copy = 2'd1; inj_mask = 32'h5; tick(1);
    inj_en = 0; tick(1);
    chk(upset_flag == 1'b1, "R9 flag pulse", {31'h0, upset_flag}, 1);
    tick(1);
    chk(upset_flag == 1'b0, "R9 flag cleared", {31'h0, upset_flag}, 0);
    run = 0;

    // R8/R9: injection while idle keeps flag up
    inj_en = 1; inj_copy = 2'd2; inj_mask = 32'h8000_0003; tick(1); inj_en = 0;
    tick(4);
    chk(upset_flag == 1'b1, "R9 idle flag", {31'h0, upset_flag}, 1);
    run = 1; tick(3); run = 0;

    // R10: copy 3 injects nothing
    inj_en = 1; inj_copy = 2'd3; inj_mask = 32'hFFFF_FFFF; tick(2); inj_en = 0;
    chk(upset_flag == 1'b0, "R10 no inject", {31'h0, upset_flag}, 0);

    // R2: clamped degrees and wider polynomials
    cfg_deg = 0; cfg_taps = 32'h3; do_load(32'h1);
    run = 1; tick(6); run = 0;
    chk((rnd_out & 32'hFFFF_FFFC) == 0, "R2 clamp low", rnd_out, rnd_out & 32'h3);
    cfg_deg = 7; cfg_taps = 32'h60; do_load(32'h55);
    run = 1; tick(130); run = 0;
    cfg_deg = 6'd40; cfg_taps = 32'h8020_0003; do_load(32'hDEAD_BEEF);
    run = 1; tick(200);
    inj_en = 1; inj_copy = 2'd0; inj_mask = 32'hFFFF_FFFF; tick(1); inj_en = 0;
    tick(50); run = 0;
    tick(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule